// File: doc/BRIEF.md
# Input Frame Alignment Shifter

This block decides where a serial PCM input frame begins, measured against a frame sync pulse, and at which bit clock edge each incoming bit is taken. It watches a bit clock, a frame sync input and several odd-numbered serial input lines, all sampled by a faster system clock. For every bit it reports the bit's position in the local frame, its time slot and the value read on each line. Each time the last bit of a time slot arrives, it also reports one assembled byte per line.

The alignment comes from an 8-bit configuration value written through a single write port. The top three bits give a whole-bit advance of 0 to 7 bit periods. The next bit selects a half-period delay, which moves the sampling instant from the falling bit clock edge to the following rising edge. Together they place the frame start anywhere from seven bit periods early to half a bit period late, in half-bit steps. A new value is held as pending and only takes over at a frame boundary.

Top module: `rx_frame_aligner`

## Requirements
- R1: While reset is asserted and after it is released, until the first sampling event, `bit_vld` and `byte_vld` are 0 and `bit_idx`, `bit_data` and `byte_data` are 0.
- R2: A sync is recognised at a rising `bclk` edge where `fsync` is 1 and was 0 at the previous rising edge. The bit period beginning there is reference position 0. Reference positions count bit periods modulo 256 (one frame = 256 bits, 32 slots of 8 bits).
- R3: The local bit index equals the reference position plus the active advance (`cfg_wdata[7:5]`), modulo 256, so the local frame begins that many bit periods before the sync. For example, 3'b110 gives six periods of advance.
- R4: With the active half-delay flag (`cfg_wdata[4]`) at 0, each bit is taken at the falling `bclk` edge inside its period. With the flag at 1, it is taken at the rising edge that ends that period, which is half a period later. Setting 8'b1001xxxx therefore gives a net advance of 3.5 periods.
- R5: When bits 7 to 4 of the active setting are all zero, the block uses standard timing: index equals the reference position and bits are taken at the falling edge. Bits 3 to 0 of a write never affect any output.
- R6: One system clock after the clock edge that detects a sampling `bclk` edge, `bit_vld` is high for one cycle. In that cycle `bit_idx` holds the index, `slot_idx` holds `bit_idx[7:3]` and `bit_data[l]` holds line l's value. At all other times `bit_vld` is 0.
- R7: Each line is shifted MSB first. When a sampled bit has index bits [2:0] equal to 7, `byte_vld` is high together with `bit_vld`. `byte_slot` then holds the slot, and `byte_data[8l+7:8l]` holds line l's last eight bits, with the earliest bit in bit 7.
- R8: A write only updates the pending setting. The active setting changes only at a sampling event whose index is 255, and it applies from the next sampling event on. A write in the same cycle as that event waits for the following boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Bit clock, sampled by clk |
| fsync | input | 1 | Frame sync pulse |
| rx_odd | input | LINES | Serial data of the odd input lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| bit_vld | output | 1 | One-cycle strobe for a sampled bit |
| bit_idx | output | 8 | Local bit index of the sampled bit |
| slot_idx | output | 5 | Time slot of the sampled bit |
| bit_data | output | LINES | Sampled value per line |
| byte_vld | output | 1 | Strobe for a completed byte |
| byte_slot | output | 5 | Slot of the completed byte |
| byte_data | output | 8*LINES | Completed byte per line, line l at bits 8l+7:8l |

## Verification
A configuration write and the adoption of the pending setting at the index-255 sample can land in the same clock cycle. The bench provokes this by predicting, from its own frame model, which step will produce the index-255 sample, and it raises `cfg_we` in exactly that step. It judges the result from the indices and sampling edges that follow. The next frame must still use the previously pending setting, and the newly written value must appear only one full frame later.

// File: rtl/rx_frame_aligner.sv
`timescale 1ns/1ps
module rx_frame_aligner #(
  parameter int LINES = 4,
  parameter int FRAME_BITS = 256,
  parameter int BW = 8,
  localparam int CW = $clog2(FRAME_BITS),
  localparam int BL = $clog2(BW),
  localparam int SW = CW - BL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              fsync,
  input  logic [LINES-1:0]  rx_odd,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic              bit_vld,
  output logic [CW-1:0]     bit_idx,
  output logic [SW-1:0]     slot_idx,
  output logic [LINES-1:0]  bit_data,
  output logic              byte_vld,
  output logic [SW-1:0]     byte_slot,
  output logic [LINES*BW-1:0] byte_data
);
  logic bclk_q, sp_last, half_act, half_pend;
  logic [2:0] adv_act, adv_pend;
  logic [CW-1:0] ref_cnt;
  logic [LINES*BW-1:0] sr;
  logic unused_low;

  wire rise     = bclk & ~bclk_q;
  wire fall     = ~bclk & bclk_q;
  wire sync_hit = rise & fsync & ~sp_last;
  wire smp      = half_act ? rise : fall;
  wire [CW-1:0] idx = ref_cnt + CW'(adv_act);
  wire last     = (idx == CW'(FRAME_BITS - 1));
  wire byte_end = &idx[BL-1:0];

  assign slot_idx   = bit_idx[CW-1:BL];
  assign unused_low = ^cfg_wdata[3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q    <= 1'b0;
      sp_last   <= 1'b0;
      ref_cnt   <= '0;
      adv_act   <= '0;
      half_act  <= 1'b0;
      adv_pend  <= '0;
      half_pend <= 1'b0;
      sr        <= '0;
      bit_vld   <= 1'b0;
      bit_idx   <= '0;
      bit_data  <= '0;
      byte_vld  <= 1'b0;
      byte_slot <= '0;
      byte_data <= '0;
    end else begin
      bclk_q   <= bclk;
      bit_vld  <= smp;
      byte_vld <= smp & byte_end;
      if (rise) begin
        sp_last <= fsync;
        ref_cnt <= sync_hit ? '0 : ref_cnt + CW'(1);
      end
      if (smp) begin
        bit_idx  <= idx;
        bit_data <= rx_odd;
        for (int l = 0; l < LINES; l++)
          sr[l*BW +: BW] <= {sr[l*BW +: BW-1], rx_odd[l]};
        if (byte_end) begin
          byte_slot <= idx[CW-1:BL];
          for (int l = 0; l < LINES; l++)
            byte_data[l*BW +: BW] <= {sr[l*BW +: BW-1], rx_odd[l]};
        end
        if (last) begin
          adv_act  <= adv_pend;
          half_act <= half_pend;
        end
      end
      if (cfg_we) begin
        adv_pend  <= cfg_wdata[7:5];
        half_pend <= cfg_wdata[4];
      end
    end
  end
endmodule

module rx_frame_aligner_chk #(
  parameter int CW = 8,
  parameter int BL = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_vld,
  input logic [CW-1:0] bit_idx,
  input logic          byte_vld,
  input logic [CW-BL-1:0] byte_slot,
  input logic [2:0]    adv_act,
  input logic          half_act
);
  // R7
  byte_with_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> bit_vld);
  // R7
  byte_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> (&bit_idx[BL-1:0]));
  // R7
  byte_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> (byte_slot == bit_idx[CW-1:BL]));
  // R8
  cfg_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({adv_act, half_act}) |-> (bit_vld && (&bit_idx)));
endmodule

bind rx_frame_aligner rx_frame_aligner_chk #(.CW(CW), .BL(BL)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_idx(bit_idx),
  .byte_vld(byte_vld), .byte_slot(byte_slot),
  .adv_act(adv_act), .half_act(half_act)
);

// File: tb/test_rx_frame_aligner.sv
`timescale 1ns/1ps
module test_rx_frame_aligner;
  localparam int LINES = 4;
  localparam int S = 5;
  localparam int NV = 8;
  localparam logic [7:0] CFG [NV] = '{8'h00, 8'hC0, 8'h90, 8'hE0, 8'h10, 8'h0F, 8'h70, 8'h9A};
  localparam int AT_IDX [NV] = '{10, 100, 255, 200, 255, 7, 128, 255};
  localparam int RUN [NV] = '{300, 600, 600, 600, 600, 600, 600, 600};

  logic clk = 0, rst_n = 0, bclk = 0, fsync = 0, cfg_we = 0;
  logic [LINES-1:0] rx_odd = '0;
  logic [7:0] cfg_wdata = '0;
  logic bit_vld, byte_vld;
  logic [7:0] bit_idx;
  logic [4:0] slot_idx, byte_slot;
  logic [LINES-1:0] bit_data;
  logic [LINES*8-1:0] byte_data;

  int checks = 0, failures = 0;
  bit done = 0;
  int n = 0, ph = 0;
  int m_ref = 0, m_adv = 0, m_padv = 0;
  bit m_half = 0, m_phalf = 0;
  logic [LINES*8-1:0] m_sr = '0;
  bit e_ev = 0, e_byte = 0;
  logic [7:0] e_idx;
  logic [LINES-1:0] e_data;
  logic [LINES*8-1:0] e_bytes;
  string e_tag;

  always #4 clk = ~clk;

  rx_frame_aligner #(.LINES(LINES)) i_rx_frame_aligner (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .rx_odd(rx_odd),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .bit_vld(bit_vld), .bit_idx(bit_idx),
    .slot_idx(slot_idx), .bit_data(bit_data), .byte_vld(byte_vld),
    .byte_slot(byte_slot), .byte_data(byte_data));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic pat(int h, int l);
    return 1'(((h * 5 + l * 3) ^ (h >> 2) ^ l) & 1);
  endfunction

  function automatic int predict();
    if ((ph == 2 && !m_half) || (ph == 0 && m_half)) return (m_ref + m_adv) & 255;
    return -1;
  endfunction

  task automatic check_prev();
    if (e_ev) begin
      chk(bit_vld == 1'b1, "R6 bit_vld", 64'(bit_vld), 1);
      chk(bit_idx == e_idx, e_tag, 64'(bit_idx), 64'(e_idx));
      chk(slot_idx == e_idx[7:3], "R6 slot_idx", 64'(slot_idx), 64'(e_idx[7:3]));
      chk(bit_data == e_data, "R4 bit_data", 64'(bit_data), 64'(e_data));
      chk(byte_vld == e_byte, "R7 byte_vld", 64'(byte_vld), 64'(e_byte));
      if (e_byte) begin
        chk(byte_slot == e_idx[7:3], "R7 byte_slot", 64'(byte_slot), 64'(e_idx[7:3]));
        chk(byte_data == e_bytes, "R7 byte_data", 64'(byte_data), 64'(e_bytes));
      end
    end else begin
      chk(bit_vld == 1'b0, "R6 no strobe", 64'(bit_vld), 0);
      chk(byte_vld == 1'b0, "R7 no strobe", 64'(byte_vld), 0);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] wd);
    int idx;
    bit sync;
    @(negedge clk);
    check_prev();
    bclk = (ph < 2);
    sync = (n >= S) && (((n - S) % 256) == 0);
    fsync = sync;
    for (int l = 0; l < LINES; l++) rx_odd[l] = pat(2 * n + (ph >= 2 ? 1 : 0), l);
    cfg_we = we;
    cfg_wdata = wd;
    idx = predict();
    if (ph == 0) m_ref = sync ? 0 : ((m_ref + 1) & 255);
    e_ev = (idx >= 0);
    e_byte = 0;
    if (e_ev) begin
      e_idx = 8'(idx);
      e_data = rx_odd;
      e_tag = (m_adv == 0 && !m_half) ? "R5 R2 bit_idx" : "R2 R3 R8 bit_idx";
      for (int l = 0; l < LINES; l++) m_sr[l*8 +: 8] = {m_sr[l*8 +: 7], rx_odd[l]};
      e_byte = (idx % 8 == 7);
      e_bytes = m_sr;
      if (idx == 255) begin
        m_adv = m_padv;
        m_half = m_phalf;
      end
    end
    if (we) begin
      m_padv = int'(wd[7:5]);
      m_phalf = wd[4];
    end
    ph = (ph + 1) % 4;
    if (ph == 0) n++;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 state under reset
    chk(bit_vld == 0 && byte_vld == 0, "R1 strobes in reset", {bit_vld, byte_vld}, 0);
    chk(bit_idx == 0 && bit_data == 0, "R1 bit outputs in reset", {bit_idx, bit_data}, 0);
    chk(byte_data == 0, "R1 byte_data in reset", 64'(byte_data), 0);
    rst_n = 1;
    @(negedge clk);
    chk(bit_vld == 0 && byte_vld == 0, "R1 strobes after release", {bit_vld, byte_vld}, 0);
    // vector table walk: write each setting at a chosen index, then run
    for (int v = 0; v < NV; v++) begin
      bit wrote = 0;
      while (!wrote) begin
        if (predict() == AT_IDX[v]) begin
          step(1'b1, CFG[v]);
          wrote = 1;
        end else step(1'b0, 8'h00);
      end
      for (int k = 0; k < RUN[v] * 4; k++) step(1'b0, 8'h00);
    end
    // R8 mid-frame writes back to back: only the last pending value is adopted
    step(1'b1, 8'h20);
    step(1'b1, 8'h50);
    for (int k = 0; k < 2400; k++) step(1'b0, 8'h00);
    step(1'b0, 8'h00);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule